// File: doc/BRIEF.md
# Two-Level Priority Bus Arbiter

This block is a central arbiter that decides which of several devices may drive a shared bus. Devices are grouped into priority levels. Each level has one request line, the OR of its devices' requests, and one grant line, which runs through that level's devices as a daisy chain. When the bus is idle and requests are present, the arbiter picks the highest level that is requesting. Within that level, the requester closest to the arbiter on the chain gets the bus.

The grant is registered. The owner keeps the bus until it raises `done_i`. Requests that arrive while the bus is owned, including requests from higher levels, do not take the bus away. After a release the bus spends one cycle idle, and arbitration then runs again. No fairness scheme is built in, so a higher level that keeps requesting can hold off a lower level for as long as it keeps doing so.

Requests are a flat vector. Device `i` sits on level `i / DEVS_PER_LEVEL`, at chain position `i % DEVS_PER_LEVEL`, where position 0 is nearest the arbiter. A higher level index means a higher priority.

Top module: `prio_bus_arbiter`

## Requirements
- R1: After reset, `gnt_o` is all zero and `busy_o` is 0.
- R2: When the bus is idle and any bit of `req_i` is set at a clock edge, after that edge exactly one grant bit is set, it belongs to a requesting device, and `busy_o` is 1.
- R3: At arbitration, a device on a higher level (larger `i / DEVS_PER_LEVEL`) wins over every device on a lower level.
- R4: At arbitration, within the winning level, the requester with the smallest position (`i % DEVS_PER_LEVEL`) wins.
- R5: While the bus is owned and `done_i` is 0, `gnt_o` does not change, whatever `req_i` does. There is no preemption.
- R6: When `done_i` is 1 while the bus is owned, after that edge `gnt_o` is zero and `busy_o` is 0, even if requests are pending.
- R7: `done_i` has no effect while the bus is idle. With no request present, `gnt_o` stays zero.
- R8: At most one bit of `gnt_o` is set at any time, and `busy_o` is 1 exactly when a bit is set.
- R9: With the bus idle and `req_i` all zero, the bus stays idle.
- R10: A higher-level device that requests continuously wins every arbitration, and a lower-level requester is never granted meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_LEVELS*DEVS_PER_LEVEL | Per-device request, grouped by level |
| done_i | input | 1 | Owner releases the bus |
| gnt_o | output | NUM_LEVELS*DEVS_PER_LEVEL | Registered one-hot grant |
| busy_o | output | 1 | Bus is owned |

## Verification
The hardest case to reach is the non-preemption window. A higher-level request has to arrive while a lower-level device already owns the bus. The bench first grants the bus to a single low-level device. It then raises every request line, including all higher-level ones, and holds `done_i` low for several cycles. During those cycles it checks that the grant does not move. The starvation case is reached by keeping one high-level and one low-level request asserted through repeated release cycles. Each new arbitration is then checked to go to the high-level device.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic {
    ARB_IDLE  = 1'b0,
    ARB_OWNED = 1'b1
  } arb_state_e;
endpackage

// File: rtl/arb_level_select.sv
module arb_level_select #(
  parameter int NUM_LEVELS = 2
) (
  input  logic [NUM_LEVELS-1:0] lvl_req_i,
  output logic [NUM_LEVELS-1:0] lvl_gnt_o
);
  // highest index wins
  for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_lvl
    if (l == NUM_LEVELS - 1) begin : g_top
      assign lvl_gnt_o[l] = lvl_req_i[l];
    end else begin : g_low
      assign lvl_gnt_o[l] = lvl_req_i[l] & ~(|lvl_req_i[NUM_LEVELS-1:l+1]);
    end
  end
endmodule

// File: rtl/arb_level_chain.sv
module arb_level_chain #(
  parameter int DEVS = 4
) (
  input  logic            chain_gnt_i,
  input  logic [DEVS-1:0] dev_req_i,
  output logic [DEVS-1:0] dev_gnt_o
);
  logic [DEVS-1:0] pass;

  assign pass[0] = chain_gnt_i;
  for (genvar p = 0; p < DEVS; p++) begin : g_dev
    assign dev_gnt_o[p] = pass[p] & dev_req_i[p];
    if (p < DEVS - 1) begin : g_fwd
      assign pass[p+1] = pass[p] & ~dev_req_i[p];
    end
  end
endmodule

// File: rtl/prio_bus_arbiter.sv
module prio_bus_arbiter #(
  parameter int NUM_LEVELS     = 2,
  parameter int DEVS_PER_LEVEL = 4
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic [NUM_LEVELS*DEVS_PER_LEVEL-1:0] req_i,
  input  logic                                 done_i,
  output logic [NUM_LEVELS*DEVS_PER_LEVEL-1:0] gnt_o,
  output logic                                 busy_o
);
  import arb_pkg::*;

  localparam int NumDevs = NUM_LEVELS * DEVS_PER_LEVEL;

  logic [NUM_LEVELS-1:0] lvl_req, lvl_gnt;
  logic [NumDevs-1:0]    winner, gnt_q;
  arb_state_e            state_q;

  for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_level
    assign lvl_req[l] = |req_i[l*DEVS_PER_LEVEL +: DEVS_PER_LEVEL];

    arb_level_chain #(.DEVS(DEVS_PER_LEVEL)) u_chain (
      .chain_gnt_i(lvl_gnt[l]),
      .dev_req_i  (req_i[l*DEVS_PER_LEVEL +: DEVS_PER_LEVEL]),
      .dev_gnt_o  (winner[l*DEVS_PER_LEVEL +: DEVS_PER_LEVEL])
    );
  end

  arb_level_select #(.NUM_LEVELS(NUM_LEVELS)) u_select (
    .lvl_req_i(lvl_req),
    .lvl_gnt_o(lvl_gnt)
  );

  // arbitrate only from idle; owner holds until done
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ARB_IDLE;
      gnt_q   <= '0;
    end else begin
      unique case (state_q)
        ARB_IDLE: if (|lvl_req) begin
          state_q <= ARB_OWNED;
          gnt_q   <= winner;
        end
        ARB_OWNED: if (done_i) begin
          state_q <= ARB_IDLE;
          gnt_q   <= '0;
        end
        default: begin
          state_q <= ARB_IDLE;
          gnt_q   <= '0;
        end
      endcase
    end
  end

  assign gnt_o  = gnt_q;
  assign busy_o = (state_q == ARB_OWNED);
endmodule

// File: rtl/prio_bus_arbiter_chk.sv
module prio_bus_arbiter_chk #(
  parameter int NUM_LEVELS     = 2,
  parameter int DEVS_PER_LEVEL = 4
) (
  input logic                                 clk_i,
  input logic                                 rst_ni,
  input logic [NUM_LEVELS*DEVS_PER_LEVEL-1:0] req_i,
  input logic                                 done_i,
  input logic [NUM_LEVELS*DEVS_PER_LEVEL-1:0] gnt_o,
  input logic                                 busy_o
);
  localparam int NumDevs = NUM_LEVELS * DEVS_PER_LEVEL;

  // devices that would have beaten the current grant holder
  logic [NumDevs-1:0] better;
  always_comb begin
    better = '0;
    for (int g = 0; g < NumDevs; g++) begin
      if (gnt_o[g]) begin
        for (int j = 0; j < NumDevs; j++) begin
          if ((j / DEVS_PER_LEVEL) > (g / DEVS_PER_LEVEL) ||
              ((j / DEVS_PER_LEVEL) == (g / DEVS_PER_LEVEL) &&
               (j % DEVS_PER_LEVEL) < (g % DEVS_PER_LEVEL)))
            better[j] = 1'b1;
        end
      end
    end
  end

  p_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o) && (busy_o == (gnt_o != '0)));

  p_grant_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_i != '0) |=> (busy_o && (gnt_o & $past(req_i)) != '0));

  // covers R4 as well
  p_prio_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ((better & $past(req_i)) == '0));

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_i) |=> $stable(gnt_o));

  p_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && done_i) |=> (!busy_o && gnt_o == '0));

  p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_i == '0) |=> (!busy_o && gnt_o == '0));
endmodule

bind prio_bus_arbiter prio_bus_arbiter_chk #(
  .NUM_LEVELS    (NUM_LEVELS),
  .DEVS_PER_LEVEL(DEVS_PER_LEVEL)
) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .req_i (req_i),
  .done_i(done_i),
  .gnt_o (gnt_o),
  .busy_o(busy_o)
);

// File: tb/prio_bus_arbiter_test.sv
module prio_bus_arbiter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req = '0;
  logic       done = 1'b0;
  logic [7:0] gnt;
  logic       busy;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         ended = 0;

  always #2 clk = ~clk;

  prio_bus_arbiter #(.NUM_LEVELS(2), .DEVS_PER_LEVEL(4)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .done_i(done),
    .gnt_o(gnt), .busy_o(busy)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string tag, logic [7:0] exp_g, logic exp_b);
    n_chk++;
    if (gnt !== exp_g || busy !== exp_b) begin
      n_bad++;
      $display("FAIL %s: gnt=%h busy=%b expected gnt=%h busy=%b",
               tag, gnt, busy, exp_g, exp_b);
    end
  endtask

  task automatic release_bus();
    req = '0; done = 1'b1; tick();
    check("R6 release", 8'h00, 1'b0);
    done = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    check("R1 reset", 8'h00, 1'b0);
    tick(); rst_n = 1'b1; tick();
    check("R1 after reset", 8'h00, 1'b0);
  endtask

  task automatic t_idle();
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R9 idle", 8'h00, 1'b0);
    end
    done = 1'b1; tick();
    check("R7 done when idle", 8'h00, 1'b0);
    done = 1'b0; tick();
    check("R7 still idle", 8'h00, 1'b0);
  endtask

  task automatic t_levels();
    req = 8'h44; tick();
    check("R3 level1 beats level0 / R2", 8'h40, 1'b1);
    release_bus();
    req = 8'h0C; tick();
    check("R2 level0 alone", 8'h04, 1'b1);
    release_bus();
  endtask

  task automatic t_chain();
    req = 8'h0A; tick();
    check("R4 nearest in level0", 8'h02, 1'b1);
    release_bus();
    req = 8'hC0; tick();
    check("R4 nearest in level1", 8'h40, 1'b1);
    release_bus();
    req = 8'hFF; tick();
    check("R4 R3 all requesting", 8'h10, 1'b1);
    release_bus();
  endtask

  task automatic t_hold();
    req = 8'h08; tick();
    check("R5 low owner granted", 8'h08, 1'b1);
    req = 8'hFF;
    for (int i = 0; i < 5; i++) begin
      tick();
      check("R5 no preemption", 8'h08, 1'b1);
    end
    done = 1'b1; tick();
    check("R6 release with pending reqs", 8'h00, 1'b0);
    done = 1'b0; req = 8'hF0; tick();
    check("R2 regrant after idle cycle", 8'h10, 1'b1);
    release_bus();
  endtask

  task automatic t_starve();
    req = 8'h11;
    for (int i = 0; i < 4; i++) begin
      tick();
      check("R10 high level wins again", 8'h10, 1'b1);
      done = 1'b1; tick();
      check("R10 released", 8'h00, 1'b0);
      done = 1'b0;
    end
    req = 8'h01; tick();
    check("R10 low wins once high drops", 8'h01, 1'b1);
    release_bus();
  endtask

  initial begin
    t_reset();
    t_idle();
    t_levels();
    t_chain();
    t_hold();
    t_starve();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!ended) begin
      ended = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule